// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block is the device-side control logic of an emulated byte-alterable nonvolatile memory. It reads the active-low chip-enable, output-enable and write-enable strobes, all synchronous to the block clock, and decodes them into read, write and inhibit modes. Each write cycle captures an address and a data byte into a page buffer. Loads keep coming while every new load starts inside a timed window. When the window runs out, the block enters a programming-busy period and copies the buffered bytes into the storage array.

During the busy period a read does not return array data. It returns a status word instead. The top bit of that word is the inverse of the top bit of the last byte loaded, and the next bit flips on every new read. A host can therefore poll for the end of programming in either of two ways. A write to a page other than the open one is dropped and signalled on a debug pulse.

The storage array is a plain synchronous RAM model. Its size, the page size, the window length and the programming length are parameters. The window and the programming time are counted in clock cycles. The defaults give 2 KiB in 128-byte pages. Setting ADDR_W to 15 gives a 32K x 8 organisation.

Top module: `nvpg_ctrl`

## Requirements
- R1: A read mode exists only while ce_n and oe_n are both low. In that mode data_oe is 1. In every other case data_oe is 0 and the bus is treated as high impedance. Outside the busy period, data_out shows the array byte at addr one cycle after addr is presented.
- R2: A write cycle exists only while ce_n is 0, we_n is 0 and oe_n is 1. Strobe patterns with oe_n low, we_n high or ce_n high write nothing and start no programming.
- R3: The load address is the addr value in the first cycle of the write cycle, which is the cycle in which the later of ce_n and we_n has fallen. The load data is the data_in value in the last cycle before the earlier of the two rises.
- R4: A page holds 2^PAGE_W bytes (128 by default), and the page address is addr[ADDR_W-1:PAGE_W]. All loads to the open page are written to the array, up to a full page. If one offset is loaded more than once, the last value wins.
- R5: A write cycle that starts while a page is open and carries a different page address is ignored. page_mismatch is then 1 for exactly one cycle, the cycle after that write cycle starts.
- R6: A page stays open while each new write cycle starts within WIN_CYC idle cycles of the previous accepted load. After WIN_CYC cycles with no write cycle active, programming begins.
- R7: Programming lasts PROG_CYC cycles, after which the array holds every loaded byte. Bytes of the page that were not loaded keep their old values.
- R8: During programming, every read returns a status word. Bit DATA_W-1 is the inverse of bit DATA_W-1 of the last loaded byte, and bits DATA_W-3 down to 0 are 0.
- R9: Status bit DATA_W-2 takes the opposite value on each successive read during programming, and it keeps its value while the block is not programming.
- R10: Write cycles that occur during programming change neither the array nor the status word.
- R11: After reset the block is idle: page_mismatch is 0, and data_oe is 0 with all strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| data_in | input | DATA_W | Write data from the host |
| data_out | output | DATA_W | Read data or, while programming, the status word |
| data_oe | output | 1 | Drive enable for data_out |
| page_mismatch | output | 1 | One-cycle pulse when a load to a foreign page is dropped |

## Verification
The assertions check on every cycle that:
- the window counter never reaches WIN_CYC while a page is open;
- programming always starts from a count of zero;
- the status top bit is inverted whenever a read occurs during programming;
- the toggle bit and the last-byte record are frozen where they must be;
- a mismatch pulse only follows an open page.

Only the bench scenarios can show the following:
- that the right bytes land at the right addresses after the busy period;
- that inhibited strobes, foreign-page loads and loads made during programming leave old contents in place;
- which of two strobe edges supplies the address and which supplies the data.

// File: rtl/nvpg_pkg.sv
package nvpg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;
endpackage

// File: rtl/nvpg_strobe.sv
// Strobe decoder: qualifies write and read modes, finds cycle boundaries,
// holds the load offset from the cycle start and the data from its last cycle.
module nvpg_strobe #(
    parameter int OFF_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [OFF_W-1:0]  addr_off,
    input  logic [DATA_W-1:0] din,
    output logic              wr_start,
    output logic              wr_end,
    output logic              wr_on,
    output logic              rd_start,
    output logic              rd_on,
    output logic [OFF_W-1:0]  lat_off,
    output logic [DATA_W-1:0] lat_data
);
    typedef struct packed {
        logic              wact;
        logic              ract;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] dat;
    } strb_t;

    strb_t s_d, s_q;
    logic  wact_now, ract_now;

    always_comb begin
        wact_now = !ce_n && !we_n && oe_n;
        ract_now = !ce_n && !oe_n;
        s_d      = s_q;
        s_d.wact = wact_now;
        s_d.ract = ract_now;
        if (wact_now && !s_q.wact) s_d.off = addr_off;
        if (wact_now)              s_d.dat = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_start = wact_now && !s_q.wact;
    assign wr_end   = !wact_now && s_q.wact;
    assign wr_on    = wact_now;
    assign rd_start = ract_now && !s_q.ract;
    assign rd_on    = ract_now;
    assign lat_off  = s_q.off;
    assign lat_data = s_q.dat;
endmodule

// File: rtl/nvpg_pagebuf.sv
// Page buffer: one byte and one valid flag per page offset.
module nvpg_pagebuf #(
    parameter int OFF_W  = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [OFF_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int DEPTH = 1 << OFF_W;

    logic [DATA_W-1:0] bytes_q [DEPTH];
    logic [DEPTH-1:0]  vld_d, vld_q;

    always_comb begin
        vld_d = vld_q;
        if (clr)        vld_d = '0;
        else if (wr_en) vld_d[wr_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) bytes_q[wr_idx] <= wr_data;
    end

    assign rd_data  = bytes_q[rd_idx];
    assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/nvpg_array.sv
// Storage array model: one write port, registered read.
module nvpg_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells_q[waddr] <= wdata;
        rdata <= cells_q[raddr];
    end
endmodule

// File: rtl/nvpg_ctrl.sv
// Top: load window, page ownership, programming period and status readout.
module nvpg_ctrl
    import nvpg_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int DATA_W   = 8,
    parameter int PAGE_W   = 7,
    parameter int WIN_CYC  = 40,
    parameter int PROG_CYC = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              page_mismatch
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PG_W       = ADDR_W - PAGE_W;
    localparam int WIN_W      = $clog2(WIN_CYC + 1);
    localparam int PRG_W      = $clog2(PROG_CYC + 1);

    typedef struct packed {
        phase_e           phase;
        logic             acc;
        logic [PG_W-1:0]  page;
        logic [WIN_W-1:0] win;
        logic [PRG_W-1:0] prg;
        logic             last_msb;
        logic             tog;
        logic             mism;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              wr_start, wr_end, wr_on, rd_start, rd_on;
    logic [PAGE_W-1:0] lat_off, cp_idx;
    logic [DATA_W-1:0] lat_data, buf_rd, arr_rd;
    logic              buf_we, buf_clr, buf_vld, cp_on, arr_we;

    nvpg_strobe #(.OFF_W(PAGE_W), .DATA_W(DATA_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr_off(addr[PAGE_W-1:0]), .din(data_in),
        .wr_start(wr_start), .wr_end(wr_end), .wr_on(wr_on),
        .rd_start(rd_start), .rd_on(rd_on),
        .lat_off(lat_off), .lat_data(lat_data)
    );

    nvpg_pagebuf #(.OFF_W(PAGE_W), .DATA_W(DATA_W)) u_pagebuf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(buf_we), .wr_idx(lat_off), .wr_data(lat_data),
        .clr(buf_clr), .rd_idx(cp_idx), .rd_data(buf_rd), .rd_valid(buf_vld)
    );

    nvpg_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .we(arr_we), .waddr({st_q.page, cp_idx}), .wdata(buf_rd),
        .raddr(addr), .rdata(arr_rd)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mism = 1'b0;
        buf_we    = 1'b0;
        buf_clr   = 1'b0;

        // an accepted load commits when its write cycle ends
        if (wr_end && st_q.acc) begin
            buf_we        = 1'b1;
            st_d.last_msb = lat_data[DATA_W-1];
            st_d.acc      = 1'b0;
        end

        case (st_q.phase)
            PH_IDLE: begin
                if (wr_start) begin
                    st_d.phase = PH_LOAD;
                    st_d.acc   = 1'b1;
                    st_d.page  = addr[ADDR_W-1:PAGE_W];
                    st_d.win   = '0;
                end
            end
            PH_LOAD: begin
                if (wr_start) begin
                    if (addr[ADDR_W-1:PAGE_W] == st_q.page) begin
                        st_d.acc = 1'b1;
                        st_d.win = '0;
                    end else begin
                        st_d.mism = 1'b1;
                    end
                end else if (!wr_on) begin
                    if (st_q.win == WIN_W'(WIN_CYC - 1)) begin
                        st_d.phase = PH_PROG;
                        st_d.prg   = '0;
                    end else begin
                        st_d.win = st_q.win + 1'b1;
                    end
                end
            end
            PH_PROG: begin
                if (rd_start) st_d.tog = ~st_q.tog;
                if (st_q.prg == PRG_W'(PROG_CYC - 1)) begin
                    st_d.phase = PH_IDLE;
                    buf_clr    = 1'b1;
                end else begin
                    st_d.prg = st_q.prg + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, default: '0};
        else        st_q <= st_d;
    end

    // copy one buffered byte per cycle during the first part of the busy period
    assign cp_idx = st_q.prg[PAGE_W-1:0];
    assign cp_on  = (st_q.phase == PH_PROG) && (st_q.prg < PRG_W'(PAGE_BYTES));
    assign arr_we = cp_on && buf_vld;

    assign data_oe       = rd_on;
    assign page_mismatch = st_q.mism;
    assign data_out      = (st_q.phase == PH_PROG)
                         ? {~st_q.last_msb, st_q.tog, {(DATA_W-2){1'b0}}}
                         : arr_rd;
endmodule

// File: rtl/nvpg_ctrl_chk.sv
module nvpg_ctrl_chk
    import nvpg_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int WIN_CYC = 40,
    parameter int WIN_W   = 6,
    parameter int PRG_W   = 9
) (
    input logic              clk,
    input logic              rst_n,
    input phase_e            phase,
    input logic [WIN_W-1:0]  win,
    input logic [PRG_W-1:0]  prg,
    input logic              last_msb,
    input logic              tog,
    input logic              page_mismatch,
    input logic              data_oe,
    input logic [DATA_W-1:0] data_out
);
    // R5
    mism_after_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_mismatch |-> $past(phase) == PH_LOAD);

    // R6
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_LOAD |-> win < WIN_W'(WIN_CYC));

    // R7
    prog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PROG && $past(phase) == PH_LOAD) |-> prg == '0);

    // R8
    status_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PROG && data_oe) |-> data_out[DATA_W-1] != last_msb);

    // R9
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_PROG && $past(phase) != PH_PROG) |-> $stable(tog));

    // R10
    prog_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PROG && $past(phase) == PH_PROG) |-> $stable(last_msb));
endmodule

bind nvpg_ctrl nvpg_ctrl_chk #(
    .DATA_W(DATA_W), .WIN_CYC(WIN_CYC), .WIN_W(WIN_W), .PRG_W(PRG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .phase(st_q.phase), .win(st_q.win),
    .prg(st_q.prg), .last_msb(st_q.last_msb), .tog(st_q.tog),
    .page_mismatch(page_mismatch), .data_oe(data_oe), .data_out(data_out)
);

// File: tb/nvpg_ctrl_test.sv
module nvpg_ctrl_test;
    localparam int AW = 11, DW = 8, PW = 7, WIN = 40, PRG = 300;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ce_n, oe_n, we_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din, dout;
    logic          doe, mism;
    int            n_tests = 0, n_fail = 0, mism_cnt = 0;
    logic [DW-1:0] model [1<<AW];

    always #2 clk = ~clk;

    nvpg_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .WIN_CYC(WIN), .PROG_CYC(PRG)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data_in(din), .data_out(dout), .data_oe(doe),
        .page_mismatch(mism)
    );

    always @(posedge clk) if (mism) mism_cnt <= mism_cnt + 1;

    function automatic logic [AW-1:0] mk(input int pg, input int off);
        return AW'((pg << PW) | off);
    endfunction

    function automatic logic [DW-1:0] exp_status(input logic [DW-1:0] last, input logic t);
        return {~last[DW-1], t, {(DW-2){1'b0}}};
    endfunction

    task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        idle(2);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] r, output logic oe_seen);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        idle(3);
        r = dout; oe_seen = doe;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load(input logic [AW-1:0] a, input logic [DW-1:0] d);
        do_write(a, d);
        model[a] = d;
    endtask

    // data polling on the last loaded address until the true top bit shows
    task automatic wait_ready(input logic [AW-1:0] a, input string req);
        logic [DW-1:0] r;
        logic          o;
        int            k;
        idle(WIN + 10);
        k = 0;
        do_read(a, r, o);
        while (r[DW-1] !== model[a][DW-1] && k < 200) begin
            do_read(a, r, o);
            k++;
        end
        chk(req, "ready poll", r, model[a]);
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input string req);
        logic [DW-1:0] r;
        logic          o;
        do_read(a, r, o);
        chk(req, "readback", r, model[a]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] r1, r2;
        logic          o;
        int            m0;
        logic [AW-1:0] ra [6];
        int            nb;
        void'($urandom(32'd4711));
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R11 reset state
        chk("R11", "data_oe", 8'(doe), 8'h00);
        chk("R11", "page_mismatch", 8'(mism), 8'h00);

        // R4 R8 R9 R1 small page with status polling
        load(mk(2, 0), 8'hA5);
        load(mk(2, 5), 8'h3C);
        load(mk(2, 127), 8'hE7);
        idle(WIN + 10);
        do_read(mk(2, 127), r1, o);
        do_read(mk(2, 127), r2, o);
        chk("R8", "status word", r1, exp_status(8'hE7, r1[DW-2]));
        chk("R9", "toggled status", r2, exp_status(8'hE7, ~r1[DW-2]));
        wait_ready(mk(2, 127), "R7");
        rd_chk(mk(2, 0), "R4");
        do_read(mk(2, 5), r1, o);
        chk("R4", "readback", r1, model[mk(2, 5)]);
        chk("R1", "data_oe in read", 8'(o), 8'h01);
        do_read(mk(2, 5), r2, o);
        chk("R9", "no toggle when idle", r2, r1);

        // R7 bytes not loaded keep old value
        load(mk(3, 5), 8'h11);
        wait_ready(mk(3, 5), "R7");
        load(mk(3, 6), 8'h22);
        wait_ready(mk(3, 6), "R7");
        rd_chk(mk(3, 5), "R7");

        // R2 inhibited strobe patterns
        @(negedge clk);
        addr = mk(3, 5); din = 8'h99; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        idle(3);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        oe_n = 1'b1; ce_n = 1'b1; we_n = 1'b0;
        idle(3);
        we_n = 1'b1;
        idle(WIN + 20);
        rd_chk(mk(3, 5), "R2");

        // R3 address from later falling strobe, data from earlier rising strobe
        load(mk(6, 1), 8'h5A);
        wait_ready(mk(6, 1), "R3");
        @(negedge clk);
        addr = mk(6, 1); din = 8'h6B; oe_n = 1'b1; we_n = 1'b0; ce_n = 1'b1;
        @(negedge clk);
        addr = mk(6, 2);
        @(negedge clk);
        ce_n = 1'b0;
        idle(2);
        we_n = 1'b1;
        @(negedge clk);
        din = 8'hF0;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        model[mk(6, 2)] = 8'h6B;
        wait_ready(mk(6, 2), "R3");
        rd_chk(mk(6, 1), "R3");

        // R5 foreign page dropped and flagged
        load(mk(5, 9), 8'h77);
        wait_ready(mk(5, 9), "R5");
        m0 = mism_cnt;
        load(mk(4, 1), 8'h44);
        do_write(mk(5, 9), 8'h88);
        chk("R5", "mismatch pulses", 8'(mism_cnt - m0), 8'h01);
        wait_ready(mk(4, 1), "R5");
        rd_chk(mk(5, 9), "R5");

        // R6 second load inside the window joins the page
        load(mk(7, 0), 8'h12);
        idle(WIN - 15);
        load(mk(7, 1), 8'h34);
        wait_ready(mk(7, 1), "R6");
        rd_chk(mk(7, 0), "R6");

        // R10 loads during programming are ignored
        load(mk(9, 3), 8'h5E);
        wait_ready(mk(9, 3), "R10");
        load(mk(9, 4), 8'hC1);
        idle(WIN + 30);
        do_write(mk(9, 3), 8'h00);
        do_read(mk(9, 4), r1, o);
        chk("R10", "status after ignored load", r1, exp_status(8'hC1, r1[DW-2]));
        wait_ready(mk(9, 4), "R10");
        rd_chk(mk(9, 3), "R10");

        // R4 full page
        for (int i = 0; i < (1 << PW); i++) load(mk(1, i), 8'((i * 7 + 3) ^ 8'h5A));
        wait_ready(mk(1, (1 << PW) - 1), "R4");
        for (int i = 0; i < (1 << PW); i++) rd_chk(mk(1, i), "R4");

        // R4 R7 random pages
        for (int it = 0; it < 8; it++) begin
            nb = 1 + int'($urandom_range(5));
            for (int j = 0; j < nb; j++) begin
                ra[j] = mk(10 + int'($urandom_range(5)) * 0 + it % 6, int'($urandom_range((1 << PW) - 1)));
                load(ra[j], 8'($urandom));
            end
            wait_ready(ra[nb-1], "R7");
            for (int j = 0; j < nb; j++) rd_chk(ra[j], "R4");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule